// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller with Register Access

This block collects a set of level-sensitive interrupt sources, grouped 32 to a bank, and presents them to one processor interrupt line. Each source has a mask bit. Software changes mask bits only through write-one registers, one that sets bits and one that clears them. Writing a zero bit leaves the matching mask bit as it was, so software never needs a read-modify-write.

When the line is idle, the controller picks the lowest-numbered source that is both asserted and unmasked. It latches that number into a readable active-source register and raises the interrupt output. The number and the output stay frozen until software writes the acknowledge bit in the control register. On the clock after that write, the controller arbitrates again. The raw input levels can be read bank by bank whatever their mask state. A self-clearing soft reset returns every register to its reset state and reports completion through a status bit after a fixed number of cycles. Software reaches all of this through a 32-bit register port with single-cycle writes and combinational reads.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After the asynchronous reset, every source is masked, `irq_o` is low, the active-source register (0x40) reads 0, and the status register (0x14) reads 1 in bit 0.
- R2: Writing the mask-clear register of bank n (0x88 + 0x20·n) unmasks source 32·n+k for every bit k written as 1. Bits written as 0 leave their mask bits unchanged.
- R3: Writing the mask-set register of bank n (0x8C + 0x20·n) masks source 32·n+k for every bit k written as 1. A masked source never raises `irq_o`.
- R4: The pending register of bank n (0x98 + 0x20·n) reads the present input levels of that bank's 32 sources, masked or not.
- R5: When `irq_o` is low, no acknowledge is being written and at least one source is both asserted and unmasked at a clock edge, then after that edge `irq_o` is high. The active-source register then holds, in bits 6:0, the lowest such source number.
- R6: While `irq_o` is high and no acknowledge is written, the active-source number and `irq_o` stay unchanged. This holds when a lower-numbered source arrives and when the selected source drops.
- R7: Writing 1 to bit 0 of the control register (0x48) drops `irq_o` after that edge. Arbitration runs again on the next clock edge.
- R8: Writing 1 to bit 1 of the configuration register (0x10) starts a soft reset. After the write edge, the status bit reads 0 for 4 cycles and then reads 1. All masks are set, `irq_o` drops, the active-source register reads 0, and the reset bit reads back 0.
- R9: Bit 0 of the configuration register is an autoidle enable. It holds the value last written to it and reads back in bit 0.
- R10: The revision register (0x00) reads the major version in bits 7:4 and the minor version in bits 3:0, with 0 in all higher bits. The defaults are 2 and 1, so the register reads 0x21.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 96 | Level-sensitive interrupt sources, bit i is source i |
| bus_we_i | input | 1 | Register write strobe, sampled at the rising edge |
| bus_addr_i | input | 8 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench unmasks a high-numbered source first and then a lower one while the first is still being served. A controller that re-arbitrates without waiting for the acknowledge would switch to the lower number mid-service. The bench also drops the selected source's level before the acknowledge, which shows whether the latched number is truly frozen or follows the inputs. After each acknowledge it samples the one idle cycle and then the re-latched number with two sources competing in different banks. A priority encoder that scans in the wrong direction, or an acknowledge that is ignored or takes effect late, shows up there. Writing mask registers with zero bits, and counting the status bit cycle by cycle through a soft reset, catches masks corrupted by zero bits and a completion count that is off by one.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  // Register byte offsets. Mask and pending offsets are for bank 0.
  localparam int unsigned OFS_VER    = 'h00;
  localparam int unsigned OFS_CFG    = 'h10;
  localparam int unsigned OFS_STAT   = 'h14;
  localparam int unsigned OFS_ACTIVE = 'h40;
  localparam int unsigned OFS_CTRL   = 'h48;
  localparam int unsigned OFS_UNMSK0 = 'h88;
  localparam int unsigned OFS_MSK0   = 'h8C;
  localparam int unsigned OFS_PEND0  = 'h98;
  localparam int unsigned BANK_STEP  = 'h20;
  localparam int unsigned BANK_W     = 32;
  localparam int unsigned DATA_W     = 32;

  // Bit positions within the configuration and control registers.
  localparam int unsigned CFG_IDLE_BIT = 0;
  localparam int unsigned CFG_SRST_BIT = 1;
  localparam int unsigned CTRL_ACK_BIT = 0;
endpackage

// File: rtl/lvl_irq_srst.sv
module lvl_irq_srst #(
  parameter int unsigned HOLD_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic hold_o,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(HOLD_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)              cnt_d = CNT_W'(HOLD_CYC);
    else if (cnt_q != '0)     cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign hold_o = start_i || (cnt_q != '0);
  assign done_o = (cnt_q == '0);

  // R8: completion reads 0 right after a start
  a_r8_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o);
  // R8: completion returns once the last hold cycle has passed
  a_r8_done_after_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_W'(1) && !start_i) |=> done_o);
endmodule

// File: rtl/lvl_irq_maskbank.sv
module lvl_irq_maskbank #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic             set_we_i,
  input  logic             clr_we_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] mask_o
);
  logic [WIDTH-1:0] mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (hold_i)        mask_d = '1;
    else if (set_we_i) mask_d = mask_q | wdata_i;
    else if (clr_we_i) mask_d = mask_q & ~wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '1;
    else         mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  // R3: every bit written as 1 to the set register ends up masked
  a_r3_set_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_we_i && !hold_i) |=> ((mask_o & $past(wdata_i)) == $past(wdata_i)));
  // R2: written-1 bits unmasked, written-0 bits unchanged
  a_r2_clr_unmasks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && !set_we_i && !hold_i) |=>
      (((mask_o & $past(wdata_i)) == '0) &&
       ((mask_o & ~$past(wdata_i)) == ($past(mask_o) & ~$past(wdata_i)))));
endmodule

// File: rtl/lvl_irq_arbiter.sv
module lvl_irq_arbiter #(
  parameter int unsigned NUM_SRC = 96,
  localparam int unsigned ID_W   = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               ack_i,
  input  logic [NUM_SRC-1:0] req_i,
  output logic               busy_o,
  output logic [ID_W-1:0]    active_o
);
  logic            busy_q, busy_d;
  logic [ID_W-1:0] act_q, act_d;
  logic [ID_W-1:0] pick;
  logic            found;

  // Lowest index wins: scan downward so the last hit is the smallest.
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        pick  = ID_W'(i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    busy_d = busy_q;
    act_d  = act_q;
    if (clr_i) begin
      busy_d = 1'b0;
      act_d  = '0;
    end else if (busy_q) begin
      if (ack_i) busy_d = 1'b0;
    end else if (found && !ack_i) begin
      busy_d = 1'b1;
      act_d  = pick;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      act_q  <= '0;
    end else begin
      busy_q <= busy_d;
      act_q  <= act_d;
    end
  end

  assign busy_o   = busy_q;
  assign active_o = act_q;

  // R5: an idle controller with a request latches on the next edge
  a_r5_latch_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !clr_i && !ack_i && (|req_i)) |=> busy_o);
  // R6: outstanding interrupt holds its number without acknowledge
  a_r6_hold_until_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !ack_i && !clr_i) |=> (busy_o && $stable(active_o)));
  // R7: acknowledge drops the request line
  a_r7_ack_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ack_i) |=> !busy_o);
  // R8: soft reset clears the selection
  a_r8_clear_selection: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!busy_o && active_o == '0));
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lvl_irq_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned ADDR_W    = 8,
  parameter logic [3:0]  VER_MAJOR = 4'd2,
  parameter logic [3:0]  VER_MINOR = 4'd1,
  parameter int unsigned SRST_CYC  = 4,
  localparam int unsigned NUM_SRC  = NUM_BANKS * BANK_W,
  localparam int unsigned ID_W     = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic               irq_o
);
  logic               hold, done, busy;
  logic               srst_start, ack, cfg_we;
  logic [ID_W-1:0]    active;
  logic [NUM_SRC-1:0] mask;
  logic               idle_q, idle_d;

  assign cfg_we     = bus_we_i && (bus_addr_i == ADDR_W'(OFS_CFG));
  assign srst_start = cfg_we && bus_wdata_i[CFG_SRST_BIT];
  assign ack        = bus_we_i && (bus_addr_i == ADDR_W'(OFS_CTRL)) &&
                      bus_wdata_i[CTRL_ACK_BIT];

  lvl_irq_srst #(.HOLD_CYC(SRST_CYC)) u_srst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (srst_start),
    .hold_o  (hold),
    .done_o  (done)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic set_we, clr_we;
    assign set_we = bus_we_i && (bus_addr_i == ADDR_W'(OFS_MSK0 + BANK_STEP * b));
    assign clr_we = bus_we_i && (bus_addr_i == ADDR_W'(OFS_UNMSK0 + BANK_STEP * b));
    lvl_irq_maskbank #(.WIDTH(BANK_W)) u_mask (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .hold_i   (hold),
      .set_we_i (set_we),
      .clr_we_i (clr_we),
      .wdata_i  (bus_wdata_i),
      .mask_o   (mask[b*BANK_W +: BANK_W])
    );
  end

  lvl_irq_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (hold),
    .ack_i    (ack),
    .req_i    (src_i & ~mask),
    .busy_o   (busy),
    .active_o (active)
  );

  // Autoidle enable
  always_comb begin
    idle_d = idle_q;
    if (hold)        idle_d = 1'b0;
    else if (cfg_we) idle_d = bus_wdata_i[CFG_IDLE_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idle_q <= 1'b0;
    else         idle_q <= idle_d;
  end

  // Read mux
  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_W'(OFS_VER))    bus_rdata_o[7:0] = {VER_MAJOR, VER_MINOR};
    if (bus_addr_i == ADDR_W'(OFS_CFG))    bus_rdata_o[CFG_IDLE_BIT] = idle_q;
    if (bus_addr_i == ADDR_W'(OFS_STAT))   bus_rdata_o[0] = done;
    if (bus_addr_i == ADDR_W'(OFS_ACTIVE)) bus_rdata_o[ID_W-1:0] = active;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bus_addr_i == ADDR_W'(OFS_PEND0 + BANK_STEP * b))
        bus_rdata_o = src_i[b*BANK_W +: BANK_W];
    end
  end

  assign irq_o = busy;

  // R3: a fully masked bank set never starts an interrupt
  a_r3_masked_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && ((src_i & ~mask) == '0)) |=> !irq_o);
  // R9: autoidle captures the written bit
  a_r9_idle_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we && !srst_start && !hold) |=> (idle_q == $past(bus_wdata_i[CFG_IDLE_BIT])));
endmodule

// File: tb/lvl_irq_ctrl_tb_top.sv
module lvl_irq_ctrl_tb_top;
  localparam time CYC = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] src = '0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0]  a;
    logic [31:0] exp;
    logic        exp_irq;
    string       tag;
  } item_t;

  item_t sb_q[$];

  always #(CYC/2) clk = ~clk;

  lvl_irq_ctrl dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .src_i       (src),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  // Monitor: pops expected items and compares the port values.
  initial begin
    forever begin
      item_t it;
      wait (sb_q.size() != 0);
      it = sb_q.pop_front();
      n_chk++;
      if (rdata !== it.exp || irq !== it.exp_irq) begin
        n_fail++;
        $display("FAIL %s: addr=0x%02h actual rdata=0x%08h irq=%0b expected rdata=0x%08h irq=%0b",
                 it.tag, it.a, rdata, irq, it.exp, it.exp_irq);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  // Sample in the current cycle, a quarter period after the falling edge.
  task automatic chk_now(input logic [7:0] a, input logic [31:0] e,
                         input logic ei, input string tag);
    item_t it;
    addr = a;
    #(CYC/4);
    it.a = a; it.exp = e; it.exp_irq = ei; it.tag = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic chk(input logic [7:0] a, input logic [31:0] e,
                     input logic ei, input string tag);
    @(negedge clk);
    chk_now(a, e, ei, tag);
  endtask

  initial begin
    #(CYC * 200000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R10 revision
    chk(8'h40, 32'd0, 1'b0, "R1 active after reset");
    chk(8'h14, 32'd1, 1'b0, "R1 status after reset");
    chk(8'h00, 32'h21, 1'b0, "R10 revision fields");

    // R4 raw levels while masked; R1 all masked so no irq
    src[5] = 1'b1; src[40] = 1'b1;
    chk(8'h98, 32'h0000_0020, 1'b0, "R4 pending bank0 while masked");
    chk(8'hB8, 32'h0000_0100, 1'b0, "R4 pending bank1 while masked");

    // R2 unmask source 40, R5 latch
    wr(8'hA8, 32'h0000_0100);
    chk(8'h40, 32'd40, 1'b1, "R5 source 40 latched");

    // R6 lower source unmasked while busy: no change
    wr(8'h88, 32'h0000_0020);
    chk(8'h40, 32'd40, 1'b1, "R6 hold despite lower source");

    // R7 acknowledge: idle cycle then lowest wins
    wr(8'h48, 32'h1);
    chk_now(8'h40, 32'd40, 1'b0, "R7 output low after acknowledge");
    chk(8'h40, 32'd5, 1'b1, "R7 R5 re-arbitration picks lowest");

    // R6 selected source drops, number stays
    src[5] = 1'b0;
    chk(8'h40, 32'd5, 1'b1, "R6 hold after source drops");

    // R3 mask 40, acknowledge: nothing left unmasked
    wr(8'hAC, 32'h0000_0100);
    wr(8'h48, 32'h1);
    chk(8'hB8, 32'h0000_0100, 1'b0, "R3 masked source stays quiet, R4 still pending");

    // R2 zero bits change nothing
    src[3] = 1'b1;
    wr(8'h88, 32'h0);
    chk(8'h98, 32'h0000_0008, 1'b0, "R2 zero write leaves source 3 masked");
    wr(8'h88, 32'h0000_0008);
    chk(8'h40, 32'd3, 1'b1, "R2 source 3 unmasked and latched");

    // Bank 2 source 70 and cross-bank priority
    src[3] = 1'b0;
    wr(8'h48, 32'h1);
    src[70] = 1'b1;
    wr(8'hC8, 32'h0000_0040);
    chk(8'h40, 32'd70, 1'b1, "R2 R5 bank2 source 70");
    chk(8'hD8, 32'h0000_0040, 1'b1, "R4 pending bank2");
    src[33] = 1'b1;
    wr(8'hA8, 32'h0000_0002);
    chk(8'h40, 32'd70, 1'b1, "R6 hold with source 33 unmasked");
    wr(8'h48, 32'h1);
    chk(8'h40, 32'd33, 1'b1, "R5 source 33 beats 70");

    // R9 autoidle
    wr(8'h10, 32'h1);
    chk(8'h10, 32'h1, 1'b1, "R9 autoidle set");
    wr(8'h10, 32'h0);
    chk(8'h10, 32'h0, 1'b1, "R9 autoidle cleared");
    wr(8'h10, 32'h1);

    // R8 soft reset
    wr(8'h10, 32'h2);
    chk_now(8'h14, 32'd0, 1'b0, "R8 status 0 cycle 1");
    chk(8'h14, 32'd0, 1'b0, "R8 status 0 cycle 2");
    chk(8'h14, 32'd0, 1'b0, "R8 status 0 cycle 3");
    chk(8'h14, 32'd0, 1'b0, "R8 status 0 cycle 4");
    chk(8'h14, 32'd1, 1'b0, "R8 status 1 after count");
    chk(8'h40, 32'd0, 1'b0, "R8 active cleared, sources masked again");
    chk(8'h10, 32'd0, 1'b0, "R8 reset bit self-clears");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule